// File: doc/BRIEF.md
# Banked work and video RAM mapper

This block turns a 16-bit CPU address into a physical address inside one of three memories. Those memories are a 16 KB video RAM in two 8 KB banks, a 32 KB work RAM in eight 4 KB banks, and a cartridge RAM of up to 128 KB in 8 KB banks. For a cartridge bank register value that points at the cartridge clock, the address goes to the clock registers instead. Beside the address it reports which memory is the target.

The block holds three bank-select registers: work RAM, video RAM and cartridge RAM. Software writes and reads them through a small configuration port. The work-RAM and video-RAM selections apply only while color mode is active. How the cartridge register is read depends on a controller-type input.

The address is decoded combinationally from the inputs and the current register values, then registered. Every result therefore appears one clock after its address. A bank change applies to accesses presented from the next cycle on.

Top module: `bankmap_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `map_target` and `map_addr` are 0. The register readback then gives 0x01 for the work-RAM bank register, 0xFE for the video-RAM bank register and 0x00 for the cartridge bank register.
- R2: Addresses 0xC000-0xCFFF give target 2 (work RAM) and physical address `cpu_addr[11:0]`, which is bank 0, whatever the registers hold.
- R3: In color mode, addresses 0xD000-0xDFFF give target 2 and physical address `bank*4096 + cpu_addr[11:0]`. Here bank is bits [2:0] of the work-RAM bank register, and a value of 0 there selects bank 1.
- R4: With color mode off, 0xD000-0xDFFF always use work-RAM bank 1, and the video-RAM bank is always 0, whatever the registers hold.
- R5: Addresses 0xE000-0xFDFF decode exactly like the address 0x2000 lower, including the current switchable work-RAM bank. Addresses 0xFE00-0xFFFF and 0x0000-0x7FFF give target 0 (none) and physical address 0.
- R6: Addresses 0x8000-0x9FFF give target 1 (video RAM) and physical address `vbank*8192 + cpu_addr[12:0]`. In color mode, vbank is bit 0 of the video-RAM bank register.
- R7: Configuration select `cfg_sel` picks a register: 0 is the work-RAM bank, 1 the video-RAM bank, 2 the cartridge bank, and 3 is no register. A write with `cfg_we` stores `cfg_wdata`. Select 3 writes are ignored. `cfg_rdata` gives, one cycle after the select, the value for that select: the full work-RAM value, the video bank bit ORed with 0xFE, the full cartridge value, or 0xFF for select 3.
- R8: Addresses 0xA000-0xBFFF give target 3 (cartridge RAM) and physical address `bank*8192 + cpu_addr[12:0]`. The bank depends on `ctrl_type`. For 0 (plain) it is 0. For 1 (type 1) it is bits [1:0] of the cartridge register. For 2 (type 3) it is bits [1:0] when the register is below 8. For 3 (type 5) it is bits [3:0].
- R9: With `ctrl_type` 2 and a cartridge register value of 8 or more, an access to 0xA000-0xBFFF gives target 4 (clock registers) and physical address equal to the register value minus 8.
- R10: The outputs for an address appear one clock after it is presented. A register write in the same cycle as an access does not affect that access, only the ones that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| color_mode | input | 1 | Enables work-RAM and video-RAM banking |
| ctrl_type | input | 2 | Cartridge controller type: 0 plain, 1 type 1, 2 type 3, 3 type 5 |
| cpu_addr | input | 16 | CPU address to map |
| cfg_we | input | 1 | Bank register write strobe |
| cfg_sel | input | 2 | Bank register select (0 work, 1 video, 2 cartridge, 3 none) |
| cfg_wdata | input | 8 | Bank register write data |
| cfg_rdata | output | 8 | Registered readback of the selected bank register |
| map_target | output | 3 | Target: 0 none, 1 video, 2 work, 3 cartridge RAM, 4 clock |
| map_addr | output | 17 | Physical address within the target |

## Verification
A bank register write and an access through the window that register controls can fall in the same cycle. The bench provokes this directly: it writes a new work-RAM bank while presenting an address in the switchable window, then repeats the access with no write. The first result must show the old bank and the second the new one. The random phase mixes writes with accesses to every window, and the bench model applies each write only after computing that cycle's expectation, so every collision is judged against the old-value rule.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  localparam logic [15:0] HIGH_IO_BASE = 16'hFE00;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_VRAM = 3'd1,
    TGT_WRAM = 3'd2,
    TGT_CART = 3'd3,
    TGT_CLK  = 3'd4
  } map_tgt_e;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_VRAM,
    RG_CART,
    RG_WFIX,
    RG_WSW
  } region_e;

  typedef enum logic [1:0] {
    CT_PLAIN = 2'd0,
    CT_TYPE1 = 2'd1,
    CT_TYPE3 = 2'd2,
    CT_TYPE5 = 2'd3
  } ctrl_e;

  localparam logic [1:0] SEL_WRAM = 2'd0;
  localparam logic [1:0] SEL_VRAM = 2'd1;
  localparam logic [1:0] SEL_CART = 2'd2;

endpackage

// File: rtl/bankmap_regs.sv
module bankmap_regs
  import bankmap_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int WB    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic [WB-1:0]    wbank_o,
  output logic             vbank_o,
  output logic [REG_W-1:0] cbank_o
);

  localparam logic [REG_W-1:0] WRAM_RST = REG_W'(1);
  localparam logic [REG_W-1:0] ALL_ONES = '1;

  logic [REG_W-1:0] wram_q;
  logic             vram_q;
  logic [REG_W-1:0] cart_q;
  logic [REG_W-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      wram_q <= WRAM_RST;
      vram_q <= 1'b0;
      cart_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_WRAM: wram_q <= cfg_wdata;
        SEL_VRAM: vram_q <= cfg_wdata[0];
        SEL_CART: cart_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_sel)
      SEL_WRAM: rd_d = wram_q;
      SEL_VRAM: rd_d = {{(REG_W-1){1'b1}}, vram_q};
      SEL_CART: rd_d = cart_q;
      default:  rd_d = ALL_ONES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_d;
  end

  assign wbank_o = wram_q[WB-1:0];
  assign vbank_o = vram_q;
  assign cbank_o = cart_q;

  // R1: register values right after reset
  a_r1_reset_vals: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wram_q == WRAM_RST) && !vram_q && (cart_q == '0));

  // R7: a select-3 write leaves every register unchanged
  a_r7_sel3_ignored: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_we) && ($past(cfg_sel) == 2'd3) && !$past(rst))
      |-> ($stable(wram_q) && $stable(vram_q) && $stable(cart_q)));

endmodule

// File: rtl/bankmap_window.sv
module bankmap_window
  import bankmap_pkg::*;
#(
  parameter int OFF_W = 13
) (
  input  logic [15:0]      addr,
  output region_e          region,
  output logic [OFF_W-1:0] offset
);

  // The echo window sits 0x2000 above the work RAM, so bits [12:0]
  // already carry the mirrored offset and bit 12 picks fixed/switchable.
  always_comb begin
    offset = addr[OFF_W-1:0];
    case (addr[15:13])
      3'd4:    region = RG_VRAM;
      3'd5:    region = RG_CART;
      3'd6:    region = addr[12] ? RG_WSW : RG_WFIX;
      3'd7: begin
        if (addr < HIGH_IO_BASE) region = addr[12] ? RG_WSW : RG_WFIX;
        else                     region = RG_NONE;
      end
      default: region = RG_NONE;
    endcase
  end

endmodule

// File: rtl/bankmap_resolve.sv
module bankmap_resolve
  import bankmap_pkg::*;
#(
  parameter int PHYS_W   = 17,
  parameter int REG_W    = 8,
  parameter int OFF_W    = 13,
  parameter int WB       = 3,
  parameter int WOFF     = 12,
  parameter int VOFF     = 13,
  parameter int CB       = 4,
  parameter int COFF     = 13,
  parameter int SMALL_CB = 2,
  parameter int CLK_BASE = 8
) (
  input  region_e           region,
  input  logic [OFF_W-1:0]  offset,
  input  logic              color,
  input  ctrl_e             ctrl,
  input  logic [WB-1:0]     wbank,
  input  logic              vbank,
  input  logic [REG_W-1:0]  cbank,
  output map_tgt_e          tgt,
  output logic [PHYS_W-1:0] phys
);

  localparam logic [REG_W-1:0] CLK_IDX = REG_W'(CLK_BASE);

  logic [WB-1:0] wsel;
  logic [CB-1:0] csel;
  logic          to_clock;

  always_comb begin
    wsel = (color && (wbank != '0)) ? wbank : WB'(1);
  end

  always_comb begin
    csel     = '0;
    to_clock = 1'b0;
    case (ctrl)
      CT_TYPE1: csel[SMALL_CB-1:0] = cbank[SMALL_CB-1:0];
      CT_TYPE3: begin
        if (cbank >= CLK_IDX) to_clock = 1'b1;
        else                  csel[SMALL_CB-1:0] = cbank[SMALL_CB-1:0];
      end
      CT_TYPE5: csel = cbank[CB-1:0];
      default:  csel = '0;
    endcase
  end

  always_comb begin
    tgt  = TGT_NONE;
    phys = '0;
    case (region)
      RG_VRAM: begin
        tgt              = TGT_VRAM;
        phys[VOFF-1:0]   = offset[VOFF-1:0];
        phys[VOFF]       = color & vbank;
      end
      RG_CART: begin
        if (to_clock) begin
          tgt               = TGT_CLK;
          phys[REG_W-1:0]   = cbank - CLK_IDX;
        end else begin
          tgt               = TGT_CART;
          phys[COFF-1:0]    = offset[COFF-1:0];
          phys[COFF +: CB]  = csel;
        end
      end
      RG_WFIX: begin
        tgt            = TGT_WRAM;
        phys[WOFF-1:0] = offset[WOFF-1:0];
      end
      RG_WSW: begin
        tgt              = TGT_WRAM;
        phys[WOFF-1:0]   = offset[WOFF-1:0];
        phys[WOFF +: WB] = wsel;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int WB     = 3,
  parameter int WOFF   = 12,
  parameter int VOFF   = 13,
  parameter int CB     = 4,
  parameter int COFF   = 13,
  parameter int PHYS_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              color_mode,
  input  logic [1:0]        ctrl_type,
  input  logic [15:0]       cpu_addr,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic [2:0]        map_target,
  output logic [PHYS_W-1:0] map_addr
);

  localparam int OFF_W = (VOFF > COFF) ? VOFF : COFF;

  logic [WB-1:0]     wbank;
  logic              vbank;
  logic [REG_W-1:0]  cbank;
  region_e           region;
  logic [OFF_W-1:0]  offset;
  map_tgt_e          tgt_d;
  logic [PHYS_W-1:0] phys_d;
  map_tgt_e          tgt_q;
  logic [PHYS_W-1:0] phys_q;
  logic              vld_q;

  bankmap_regs #(.REG_W(REG_W), .WB(WB)) regs_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wbank_o(wbank), .vbank_o(vbank), .cbank_o(cbank)
  );

  bankmap_window #(.OFF_W(OFF_W)) win_i (
    .addr(cpu_addr), .region(region), .offset(offset)
  );

  bankmap_resolve #(
    .PHYS_W(PHYS_W), .REG_W(REG_W), .OFF_W(OFF_W), .WB(WB), .WOFF(WOFF),
    .VOFF(VOFF), .CB(CB), .COFF(COFF)
  ) res_i (
    .region(region), .offset(offset), .color(color_mode),
    .ctrl(ctrl_e'(ctrl_type)), .wbank(wbank), .vbank(vbank), .cbank(cbank),
    .tgt(tgt_d), .phys(phys_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= TGT_NONE;
      phys_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      tgt_q  <= tgt_d;
      phys_q <= phys_d;
      vld_q  <= 1'b1;
    end
  end

  assign map_target = tgt_q;
  assign map_addr   = phys_q;

  // R2: the fixed work-RAM window never leaves bank 0
  a_r2_fixed_bank: assert property (@(posedge clk) disable iff (rst)
    (vld_q && (tgt_q == TGT_WRAM) && !$past(cpu_addr[12]))
      |-> (phys_q[PHYS_W-1:WOFF] == '0));

  // R3: the switchable work-RAM window never lands in bank 0
  a_r3_no_bank0: assert property (@(posedge clk) disable iff (rst)
    (vld_q && (tgt_q == TGT_WRAM) && $past(cpu_addr[12]))
      |-> (phys_q[WOFF +: WB] != '0));

  // R4: without color mode the video RAM stays in bank 0
  a_r4_mono_vram: assert property (@(posedge clk) disable iff (rst)
    (vld_q && (tgt_q == TGT_VRAM) && !$past(color_mode))
      |-> !phys_q[VOFF]);

  // R5: the top page maps to nothing
  a_r5_high_none: assert property (@(posedge clk) disable iff (rst)
    (vld_q && ($past(cpu_addr) >= HIGH_IO_BASE))
      |-> ((tgt_q == TGT_NONE) && (phys_q == '0)));

  // R9: only the type 3 controller redirects to the clock registers
  a_r9_clock_type3: assert property (@(posedge clk) disable iff (rst)
    (vld_q && (tgt_q == TGT_CLK)) |-> ($past(ctrl_type) == CT_TYPE3));

endmodule

// File: tb/bankmap_top_tb_top.sv
`timescale 1ns/1ps
module bankmap_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        color_mode = 1'b0;
  logic [1:0]  ctrl_type = 2'd0;
  logic [15:0] cpu_addr = 16'h0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'h0;
  logic [7:0]  cfg_rdata;
  logic [2:0]  map_target;
  logic [16:0] map_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0]  sh_w = 8'h01;
  logic        sh_v = 1'b0;
  logic [7:0]  sh_c = 8'h00;
  bit          pend = 0;
  logic [2:0]  e_tgt;
  logic [16:0] e_phys;
  logic [7:0]  e_rd;
  string       e_tag;
  string       e_rtag;

  always #2 clk = ~clk;

  bankmap_top dut_i (
    .clk(clk), .rst(rst), .color_mode(color_mode), .ctrl_type(ctrl_type),
    .cpu_addr(cpu_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .map_target(map_target), .map_addr(map_addr)
  );

  function automatic logic [19:0] ref_map(input logic [15:0] a, input logic col,
      input logic [1:0] ct, input logic [7:0] w, input logic v, input logic [7:0] c);
    logic [2:0]  t;
    logic [16:0] p;
    logic [15:0] m;
    logic [2:0]  wb;
    t = 3'd0;
    p = '0;
    if (a >= 16'h8000 && a <= 16'h9FFF) begin
      t = 3'd1;
      p = {3'b000, col & v, a[12:0]};
    end else if (a >= 16'hA000 && a <= 16'hBFFF) begin
      t = 3'd3;
      case (ct)
        2'd1: p = {2'b00, c[1:0], a[12:0]};
        2'd2: begin
          if (c >= 8'd8) begin
            t = 3'd4;
            p = {9'b0, c - 8'd8};
          end else p = {2'b00, c[1:0], a[12:0]};
        end
        2'd3: p = {c[3:0], a[12:0]};
        default: p = {4'b0, a[12:0]};
      endcase
    end else if (a >= 16'hC000 && a <= 16'hFDFF) begin
      m = (a >= 16'hE000) ? a - 16'h2000 : a;
      t = 3'd2;
      if (m < 16'hD000) p = {5'b0, m[11:0]};
      else begin
        wb = (col && w[2:0] != 3'd0) ? w[2:0] : 3'd1;
        p = {2'b00, wb, m[11:0]};
      end
    end
    return {t, p};
  endfunction

  function automatic logic [7:0] ref_rd(input logic [1:0] s, input logic [7:0] w,
      input logic v, input logic [7:0] c);
    case (s)
      2'd0: return w;
      2'd1: return {7'h7F, v};
      2'd2: return c;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] a, input logic col,
      input logic [1:0] ct, input logic [7:0] c);
    if (a >= 16'h8000 && a <= 16'h9FFF) return col ? "R6" : "R4";
    if (a >= 16'hA000 && a <= 16'hBFFF) return (ct == 2'd2 && c >= 8'd8) ? "R9" : "R8";
    if (a >= 16'hC000 && a <= 16'hCFFF) return "R2";
    if (a >= 16'hD000 && a <= 16'hDFFF) return col ? "R3" : "R4";
    return "R5";
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input bit we, input logic [1:0] sel,
      input logic [7:0] d, input logic col, input logic [1:0] ct, input string tag);
    @(negedge clk);
    if (pend) begin
      chk(e_tag, "map_target", int'(map_target), int'(e_tgt));
      chk(e_tag, "map_addr", int'(map_addr), int'(e_phys));
      chk(e_rtag, "cfg_rdata", int'(cfg_rdata), int'(e_rd));
    end
    cpu_addr = a; cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    color_mode = col; ctrl_type = ct;
    {e_tgt, e_phys} = ref_map(a, col, ct, sh_w, sh_v, sh_c);
    e_rd   = ref_rd(sel, sh_w, sh_v, sh_c);
    e_tag  = (tag == "") ? tag_of(a, col, ct, sh_c) : tag;
    e_rtag = (tag == "") ? "R7" : tag;
    pend   = 1;
    if (we) begin
      case (sel)
        2'd0: sh_w = d;
        2'd1: sh_v = d[0];
        2'd2: sh_c = d;
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra;
    logic [7:0]  rd;
    logic        rcol;
    logic [1:0]  rct;
    void'($urandom(32'd20517));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "map_target after reset", int'(map_target), 0);
    chk("R1", "map_addr after reset", int'(map_addr), 0);
    // R1: readback of reset values
    step(16'h0000, 0, 2'd0, 8'h00, 0, 2'd0, "R1");
    step(16'h0000, 0, 2'd1, 8'h00, 0, 2'd0, "R1");
    step(16'h0000, 0, 2'd2, 8'h00, 0, 2'd0, "R1");
    // R4: banking ignored without color mode
    step(16'hC000, 1, 2'd0, 8'h05, 0, 2'd0, "R2");
    step(16'hD123, 0, 2'd0, 8'h00, 0, 2'd0, "R4");
    // R3: bank 5, then bank 0 aliasing to 1, then high bits ignored
    step(16'hD123, 0, 2'd0, 8'h00, 1, 2'd0, "R3");
    step(16'hC123, 1, 2'd0, 8'h00, 1, 2'd0, "R2");
    step(16'hD123, 0, 2'd0, 8'h00, 1, 2'd0, "R3");
    step(16'hCFFF, 1, 2'd0, 8'hF6, 1, 2'd0, "R2");
    step(16'hD123, 0, 2'd0, 8'h00, 1, 2'd0, "R3");
    // R5: echo follows bank 6, top page and low space are unmapped
    step(16'hF123, 0, 2'd0, 8'h00, 1, 2'd0, "R5");
    step(16'hE456, 0, 2'd0, 8'h00, 1, 2'd0, "R5");
    step(16'hFDFF, 0, 2'd0, 8'h00, 1, 2'd0, "R5");
    step(16'hFE00, 0, 2'd0, 8'h00, 1, 2'd0, "R5");
    step(16'h7FFF, 0, 2'd0, 8'h00, 1, 2'd0, "R5");
    // R6 / R4: video bank
    step(16'h0000, 1, 2'd1, 8'hFF, 1, 2'd0, "R7");
    step(16'h9ABC, 0, 2'd1, 8'h00, 1, 2'd0, "R6");
    step(16'h9ABC, 0, 2'd1, 8'h00, 0, 2'd0, "R4");
    // R8 / R9: cartridge bank per controller type
    step(16'h0000, 1, 2'd2, 8'h0A, 1, 2'd2, "R8");
    step(16'hA005, 0, 2'd2, 8'h00, 1, 2'd2, "R9");
    step(16'hA005, 0, 2'd2, 8'h00, 1, 2'd1, "R8");
    step(16'hBFFF, 0, 2'd2, 8'h00, 1, 2'd3, "R8");
    step(16'hA005, 0, 2'd2, 8'h00, 1, 2'd0, "R8");
    step(16'h0000, 1, 2'd2, 8'h07, 1, 2'd2, "R8");
    step(16'hA100, 0, 2'd2, 8'h00, 1, 2'd2, "R8");
    step(16'h0000, 1, 2'd2, 8'h08, 1, 2'd2, "R9");
    step(16'hB000, 0, 2'd2, 8'h00, 1, 2'd2, "R9");
    // R7: select 3 write ignored, readback of every register
    step(16'h0000, 1, 2'd3, 8'h55, 1, 2'd0, "R7");
    step(16'h0000, 0, 2'd0, 8'h00, 1, 2'd0, "R7");
    step(16'h0000, 0, 2'd1, 8'h00, 1, 2'd0, "R7");
    step(16'h0000, 0, 2'd2, 8'h00, 1, 2'd0, "R7");
    // R10: write and access in the same cycle
    step(16'h0000, 1, 2'd0, 8'h02, 1, 2'd0, "R10");
    step(16'hD010, 1, 2'd0, 8'h03, 1, 2'd0, "R10");
    step(16'hD010, 0, 2'd0, 8'h00, 1, 2'd0, "R10");
    // random phase
    rcol = 1'b1;
    rct  = 2'd0;
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 8)
        0: ra = {3'b100, 13'($urandom)};
        1: ra = {3'b101, 13'($urandom)};
        2, 6: ra = {3'b110, 13'($urandom)};
        3, 7: ra = {3'b111, 13'($urandom)};
        4: ra = 16'hFE00 | 16'($urandom % 512);
        default: ra = 16'($urandom);
      endcase
      rd = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 20);
      if ($urandom % 16 == 0) rcol = ~rcol;
      if ($urandom % 16 == 0) rct = 2'($urandom);
      step(ra, ($urandom % 4) == 0, 2'($urandom), rd, rcol, rct, "");
    end
    step(16'h0000, 0, 2'd0, 8'h00, rcol, rct, "R7");
    @(negedge clk);
    chk(e_tag, "map_target", int'(map_target), int'(e_tgt));
    chk(e_tag, "map_addr", int'(map_addr), int'(e_phys));
    chk(e_rtag, "cfg_rdata", int'(cfg_rdata), int'(e_rd));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule